// File: doc/BRIEF.md
# DDR SDRAM command sequencer

This block sits between a simple request source and a four-bank double-data-rate DRAM. It accepts one access at a time on a valid/ready handshake. Each access carries a bank, a row, a column, a read/write direction and an auto-precharge flag. The block turns the access into a legal stream of commands on an active-low command bus. It remembers which row is open in each bank. From that it decides whether the access can go straight to a column command, needs an activate first, or needs a precharge, then an activate, then the column command. A free-running refresh timer forces an Auto Refresh before the maximum average refresh interval runs out. All banks are closed first when any is open. New requests are held off while refresh is pending or running.

The timing gaps are set in clock cycles by parameters: activate to column, precharge to activate, and refresh recovery. The refresh interval is a parameter as well, 1170 cycles by default, which is 7.8 µs at 150 MHz. Burst length and CAS latency come in as static configuration inputs and are decoded for the data path. The block issues at most one command per clock. The memory registers each command on the rising edge, and every cycle without a legal command carries NOP.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is low, the command bus carries NOP and `req_ready` is low.
- R2: A request to a bank whose open row equals the request row issues its Read (`0101`) or Write (`0100`) in the cycle after the handshake edge. The address carries the column in bits 9:0 and the auto-precharge flag in bit 10.
- R3: A request to a closed bank issues Active (`0011`) with the row on the address bus in the cycle after the handshake. The column command follows exactly T_RCD cycles later, with NOP in between.
- R4: A request to a bank whose open row differs issues Precharge (`0010`, address bit 10 low, address zero) in the cycle after the handshake. Active follows T_RP cycles later and the column command T_RCD cycles after that.
- R5: Command encodings on {cs_n, ras_n, cas_n, we_n} are NOP `0111`, Active `0011`, Read `0101`, Write `0100`, Precharge `0010` and Auto Refresh `0001`. No other code appears.
- R6: `req_ready` is high only when the block is idle with no refresh pending. It is low in every cycle in which a command other than NOP is driven.
- R7: A column command with auto precharge closes its bank. The next access to that bank starts with Active, not Precharge, and no Active reaches that bank earlier than BL/2 + T_RP cycles after the column command.
- R8: Auto Refresh (`0001`) commands are never more than T_REFI cycles apart, counted from the release of reset for the first one.
- R9: Auto Refresh is issued only with all banks closed. If any bank is open, a precharge-all (Precharge with address bit 10 high) goes first, at least T_RP cycles before the refresh. No command follows a refresh for T_RFC cycles.
- R10: `cfg_burst` code 00 selects 2 beats, 01 selects 4 and 10 or 11 select 8, shown on `dp_burst_beats`. Successive column commands are at least BL/2 cycles apart.
- R11: `dp_cl_half` follows `cfg_cl_half`: 0 selects CAS latency 2 and 1 selects 2.5.
- R12: Every cycle in which no command is legal carries NOP, including all wait cycles between the commands of one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change after its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst | input | 2 | Burst length code (00=2, 01=4, 1x=8), static while requests run |
| cfg_cl_half | input | 1 | CAS latency select (0 = 2, 1 = 2.5) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a rising edge when both are high |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after this burst |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| cmd_bank | output | 2 | Bank address of the command |
| cmd_addr | output | ROW_W | Row, or column with bit 10 as the precharge flag |
| dp_burst_beats | output | 4 | Decoded burst length for the data path |
| dp_cl_half | output | 1 | CAS latency select for the data path |

## Verification
When a request is accepted on rising edge h, its first command sits on the bus during the cycle that follows h. Active comes T_RP cycles after a precharge and the column command T_RCD cycles after Active. The configuration outputs follow their inputs in the same cycle. Refresh must land no later than T_REFI cycles after the previous one. The bench drives and samples on falling edges and timestamps each value with a count of rising edges. It computes the expected cycle of every command from its own model of bank state, built from the commands it has seen. It then checks the code, bank and address at exactly that cycle and NOP in every cycle in between. A separate falling-edge monitor checks the minimum gaps and the bank-state legality of every command, including those of refresh sequences that no request triggered.

// File: rtl/ddr_seq_pkg.sv
// Shared types for the DDR command sequencer.
// Command codes are {cs_n, ras_n, cas_n, we_n}; sequencer states are internal.
package ddr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_PREALL,
        ST_REF,
        ST_WAIT
    } seq_st_e;

    // Burst code to beats: 00 -> 2, 01 -> 4, 10/11 -> 8.
    function automatic logic [3:0] beats_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/gap_timer.sv
// Down-counter that times the wait between two commands.
// Assumes load values of at least 1; last is high in the final wait cycle.
module gap_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Load on a command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/ref_timer.sv
// Counts cycles since the last Auto Refresh and raises pend early enough
// (LEAD cycles before T_REFI) for any access in flight to finish first.
// Assumes T_REFI > LEAD.
module ref_timer #(
    parameter int T_REFI = 1170,
    parameter int LEAD   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic pend
);
    localparam int W   = $clog2(T_REFI + 1);
    localparam int THR = T_REFI - LEAD;

    logic [W-1:0] cnt;

    // Restart on each refresh, saturate at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (ref_done)              cnt <= '0;
        else if (cnt != W'(T_REFI))     cnt <= cnt + 1'b1;
    end

    assign pend = (cnt >= W'(THR));
endmodule

// File: rtl/bank_rows.sv
// Open/closed flag and open-row register for each bank.
// Assumes at most one open and one close per cycle; close_all wins.
module bank_rows #(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    localparam int BA_W = $clog2(NB)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      open_en,
    input  logic [BA_W-1:0]           open_bank,
    input  logic [ROW_W-1:0]          open_row,
    input  logic                      close_en,
    input  logic [BA_W-1:0]           close_bank,
    input  logic                      close_all,
    output logic [NB-1:0]             bank_open,
    output logic [NB-1:0][ROW_W-1:0]  bank_row
);
    for (genvar i = 0; i < NB; i++) begin : g_bank
        // Track one bank's row state from the issued commands.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[i] <= 1'b0;
                bank_row[i]  <= '0;
            end else if (close_all) begin
                bank_open[i] <= 1'b0;
            end else if (open_en && open_bank == BA_W'(i)) begin
                bank_open[i] <= 1'b1;
                bank_row[i]  <= open_row;
            end else if (close_en && close_bank == BA_W'(i)) begin
                bank_open[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr_cmd_seq.sv
// DDR SDRAM command sequencer: one request at a time becomes a timed
// Precharge/Active/Read/Write stream; periodic Auto Refresh is forced.
// Assumes T_RP, T_RCD, T_RFC >= 2, ROW_W >= 11, COL_W <= 10, cfg_* static
// while requests are in flight.
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RFC  = 10,
    parameter int T_REFI = 1170
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_burst,
    input  logic             cfg_cl_half,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic             req_autopre,
    output logic [3:0]       cmd_n,
    output logic [1:0]       cmd_bank,
    output logic [ROW_W-1:0] cmd_addr,
    output logic [3:0]       dp_burst_beats,
    output logic             dp_cl_half
);
    localparam int NB     = 4;
    localparam int BA_W   = 2;
    localparam int AP_BIT = 10;
    localparam int LEAD   = 3 * T_RP + T_RCD + 12;
    localparam int MAXW   = T_RFC + T_RP + T_RCD + 8;
    localparam int CNT_W  = $clog2(MAXW + 1);

    seq_st_e                  st, st_after;
    logic [BA_W-1:0]          cur_bank;
    logic [ROW_W-1:0]         cur_row;
    logic [COL_W-1:0]         cur_col;
    logic                     cur_wr, cur_ap, close_on_exit;
    logic [NB-1:0]            bank_open;
    logic [NB-1:0][ROW_W-1:0] bank_row;
    logic                     ref_pend, gap_last, gap_load;
    logic [CNT_W-1:0]         gap_val, burst_cyc;
    logic [3:0]               beats;
    logic [ROW_W-1:0]         col_addr;

    assign beats          = beats_of(cfg_burst);
    assign burst_cyc      = CNT_W'(beats >> 1);
    assign dp_burst_beats = beats;
    assign dp_cl_half     = cfg_cl_half;
    assign req_ready      = rst_n && (st == ST_IDLE) && !ref_pend;

    bank_rows #(.NB(NB), .ROW_W(ROW_W)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (st == ST_ACT),
        .open_bank  (cur_bank),
        .open_row   (cur_row),
        .close_en   ((st == ST_PRE) || (st == ST_WAIT && gap_last && close_on_exit)),
        .close_bank (cur_bank),
        .close_all  (st == ST_PREALL),
        .bank_open  (bank_open),
        .bank_row   (bank_row)
    );

    ref_timer #(.T_REFI(T_REFI), .LEAD(LEAD)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_done (st == ST_REF),
        .pend     (ref_pend)
    );

    gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .last     (gap_last)
    );

    // Wait length that follows each command state.
    always_comb begin
        gap_load = 1'b1;
        gap_val  = '0;
        case (st)
            ST_PRE, ST_PREALL: gap_val = CNT_W'(T_RP - 1);
            ST_ACT:            gap_val = CNT_W'(T_RCD - 1);
            ST_COL:            gap_val = cur_ap ? burst_cyc + CNT_W'(T_RP - 1) : burst_cyc;
            ST_REF:            gap_val = CNT_W'(T_RFC - 1);
            default:           gap_load = 1'b0;
        endcase
    end

    // Sequencer: accept, classify against the bank table, step through commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            st_after      <= ST_IDLE;
            cur_bank      <= '0;
            cur_row       <= '0;
            cur_col       <= '0;
            cur_wr        <= 1'b0;
            cur_ap        <= 1'b0;
            close_on_exit <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ref_pend) begin
                        st <= (|bank_open) ? ST_PREALL : ST_REF;
                    end else if (req_valid) begin
                        cur_bank <= req_bank;
                        cur_row  <= req_row;
                        cur_col  <= req_col;
                        cur_wr   <= req_write;
                        cur_ap   <= req_autopre;
                        if (!bank_open[req_bank])                 st <= ST_ACT;
                        else if (bank_row[req_bank] == req_row)   st <= ST_COL;
                        else                                      st <= ST_PRE;
                    end
                end
                ST_PRE:    begin st <= ST_WAIT; st_after <= ST_ACT;  end
                ST_ACT:    begin st <= ST_WAIT; st_after <= ST_COL;  end
                ST_COL:    begin st <= ST_WAIT; st_after <= ST_IDLE; close_on_exit <= cur_ap; end
                ST_PREALL: begin st <= ST_WAIT; st_after <= ST_REF;  end
                ST_REF:    begin st <= ST_WAIT; st_after <= ST_IDLE; end
                default: begin
                    if (gap_last) begin
                        st            <= st_after;
                        close_on_exit <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Column address with the auto-precharge flag in its fixed bit.
    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = cur_col;
        col_addr[AP_BIT]      = cur_ap;
    end

    // Command bus decode from the current state; NOP otherwise.
    always_comb begin
        cmd_n    = CMD_NOP;
        cmd_bank = cur_bank;
        cmd_addr = '0;
        case (st)
            ST_PRE: cmd_n = CMD_PRE;
            ST_ACT: begin
                cmd_n    = CMD_ACT;
                cmd_addr = cur_row;
            end
            ST_COL: begin
                cmd_n    = cur_wr ? CMD_WR : CMD_RD;
                cmd_addr = col_addr;
            end
            ST_PREALL: begin
                cmd_n            = CMD_PRE;
                cmd_bank         = '0;
                cmd_addr[AP_BIT] = 1'b1;
            end
            ST_REF: begin
                cmd_n    = CMD_REF;
                cmd_bank = '0;
            end
            default: cmd_n = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/ddr_seq_chk.sv
// Assertion checker for ddr_cmd_seq, attached by bind below.
// Observes the command bus, the handshake and the bank/refresh state.
module ddr_seq_chk #(
    parameter int T_REFI = 1170
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd_n,
    input logic [1:0] cmd_bank,
    input logic       req_ready,
    input logic [3:0] bank_open,
    input logic       ref_pend
);
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;

    int since_ref;

    // Count cycles since reset release or the last refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_n == K_REF) since_ref <= 0;
        else                          since_ref <= since_ref + 1;
    end

    // R1: quiet bus and no acceptance while reset is held.
    always @(negedge clk) begin
        if (!rst_n)
            a_r1_reset_nop: assert (cmd_n == K_NOP && !req_ready);
    end

    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n != K_NOP) |-> !req_ready);

    a_r6_ref_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

    a_r3_act_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == K_ACT) |-> !bank_open[cmd_bank]);

    a_r2_col_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == K_RD || cmd_n == K_WR) |-> bank_open[cmd_bank]);

    a_r9_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == K_REF) |-> (bank_open == 4'b0000));

    a_r12_pre_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == K_PRE) |=> (cmd_n == K_NOP));

    a_r8_refresh_interval: assert property (@(posedge clk) disable iff (!rst_n)
        since_ref < T_REFI);
endmodule

bind ddr_cmd_seq ddr_seq_chk #(.T_REFI(T_REFI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_n     (cmd_n),
    .cmd_bank  (cmd_bank),
    .req_ready (req_ready),
    .bank_open (bank_open),
    .ref_pend  (ref_pend)
);

// File: tb/sim_ddr_cmd_seq.sv
// Bench for ddr_cmd_seq: directed corner cases then seeded random requests.
module sim_ddr_cmd_seq;
    localparam int ROW_W = 13, COL_W = 10;
    localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, T_REFI = 1170;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101;
    localparam logic [3:0] C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_burst = 2'b01;
    logic cfg_cl_half = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_write = 1'b0, req_autopre = 1'b0;
    logic [3:0] cmd_n, dp_burst_beats;
    logic [1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_addr;
    logic dp_cl_half;

    ddr_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
                  .T_RFC(T_RFC), .T_REFI(T_REFI)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_cl_half(cfg_cl_half),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .req_autopre(req_autopre), .cmd_n(cmd_n), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .dp_burst_beats(dp_burst_beats), .dp_cl_half(dp_cl_half)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit done = 1'b0, mon_on = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    function automatic int bl_cyc(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
    endfunction

    function automatic int beats_exp(input logic [1:0] code);
        return 2 * bl_cyc(code);
    endfunction

    // Bench model of bank state, built only from observed commands.
    bit m_open[4];
    logic [ROW_W-1:0] m_row[4];
    int t_act[4], t_pre[4], t_apc[4];
    int t_col = -1000, t_ref = 0, nref = 0, npreall = 0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 1'b0; m_row[i] = '0;
            t_act[i] = -1000; t_pre[i] = -1000; t_apc[i] = -1000;
        end
    end

    // Monitor: legality and gaps of every command on the bus.
    always @(negedge clk) begin
        int b;
        if (mon_on && cmd_n != C_NOP) begin
            b = int'(cmd_bank);
            chk(!req_ready, "R6 ready low while a command is driven", req_ready, 0);
            chk(cmd_n inside {C_ACT, C_RD, C_WR, C_PRE, C_REF}, "R5 legal command code", cmd_n, C_NOP);
            if (cmd_n != C_REF)
                chk(cyc - t_ref >= T_RFC, "R9 no command within tRFC of refresh", cyc - t_ref, T_RFC);
            case (cmd_n)
                C_ACT: begin
                    chk(!m_open[b], "R3 activate only a closed bank", m_open[b], 0);
                    chk(cyc - t_pre[b] >= T_RP, "R4 precharge to activate gap", cyc - t_pre[b], T_RP);
                    chk(cyc - t_apc[b] >= bl_cyc(cfg_burst) + T_RP, "R7 auto-precharge to activate gap",
                        cyc - t_apc[b], bl_cyc(cfg_burst) + T_RP);
                    m_open[b] = 1'b1; m_row[b] = cmd_addr; t_act[b] = cyc;
                end
                C_RD, C_WR: begin
                    chk(m_open[b], "R2 column command to an open bank", m_open[b], 1);
                    chk(cyc - t_act[b] >= T_RCD, "R3 activate to column gap", cyc - t_act[b], T_RCD);
                    chk(cyc - t_col >= bl_cyc(cfg_burst), "R10 column to column gap",
                        cyc - t_col, bl_cyc(cfg_burst));
                    t_col = cyc;
                    if (cmd_addr[10]) begin
                        m_open[b] = 1'b0; t_apc[b] = cyc;
                    end
                end
                C_PRE: begin
                    if (cmd_addr[10]) begin
                        npreall++;
                        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; t_pre[i] = cyc; end
                    end else begin
                        chk(m_open[b], "R4 single precharge of an open bank", m_open[b], 1);
                        m_open[b] = 1'b0; t_pre[b] = cyc;
                    end
                end
                default: begin
                    for (int i = 0; i < 4; i++) begin
                        chk(!m_open[i], "R9 refresh with all banks closed", m_open[i], 0);
                        chk(cyc - t_pre[i] >= T_RP, "R9 precharge to refresh gap", cyc - t_pre[i], T_RP);
                    end
                    chk(cyc - t_ref <= T_REFI, "R8 refresh interval", cyc - t_ref, T_REFI);
                    t_ref = cyc; nref++;
                end
            endcase
        end
    end

    task automatic expect_cmd(input logic [3:0] code, input int b, input logic [ROW_W-1:0] addr,
                              input string what);
        chk(cmd_n == code, {what, " code"}, cmd_n, code);
        chk(int'(cmd_bank) == b, {what, " bank"}, cmd_bank, b);
        chk(cmd_addr == addr, {what, " address"}, cmd_addr, addr);
        @(negedge clk);
    endtask

    task automatic expect_nops(input int n, input string what);
        for (int i = 0; i < n; i++) begin
            chk(cmd_n == C_NOP, what, cmd_n, C_NOP);
            @(negedge clk);
        end
    endtask

    // One request: handshake, then every command checked at its own cycle.
    task automatic do_req(input int b, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                          input bit wr, input bit ap);
        int kind;
        logic [3:0] ccode;
        logic [ROW_W-1:0] caddr;
        req_bank = 2'(b); req_row = row; req_col = col; req_write = wr; req_autopre = ap;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        kind = !m_open[b] ? 1 : (m_row[b] == row ? 0 : 2);
        @(negedge clk);
        req_valid = 1'b0;
        ccode = wr ? C_WR : C_RD;
        caddr = ROW_W'(col) | (ap ? ROW_W'(1024) : ROW_W'(0));
        case (kind)
            0: expect_cmd(ccode, b, caddr, "R2 row hit column command");
            1: begin
                expect_cmd(C_ACT, b, row, "R3 activate");
                expect_nops(T_RCD - 1, "R12 NOP while waiting tRCD");
                expect_cmd(ccode, b, caddr, "R3 column after tRCD");
            end
            default: begin
                expect_cmd(C_PRE, b, '0, "R4 precharge on row miss");
                expect_nops(T_RP - 1, "R12 NOP while waiting tRP");
                expect_cmd(C_ACT, b, row, "R4 activate after tRP");
                expect_nops(T_RCD - 1, "R12 NOP while waiting tRCD");
                expect_cmd(ccode, b, caddr, "R4 column after tRCD");
            end
        endcase
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int r0, p0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(cmd_n == C_NOP, "R1 NOP during reset", cmd_n, C_NOP);
        chk(!req_ready, "R1 ready low during reset", req_ready, 0);
        rst_n = 1'b1;
        t_ref = cyc;
        mon_on = 1'b1;
        @(negedge clk);
        chk(req_ready, "R6 ready when idle after reset", req_ready, 1);

        for (int c = 0; c < 4; c++) begin
            cfg_burst = 2'(c);
            #1 chk(int'(dp_burst_beats) == beats_exp(2'(c)), "R10 burst length decode",
                   dp_burst_beats, beats_exp(2'(c)));
        end
        cfg_cl_half = 1'b1;
        #1 chk(dp_cl_half == 1'b1, "R11 CAS latency 2.5 select", dp_cl_half, 1);
        cfg_cl_half = 1'b0;
        #1 chk(dp_cl_half == 1'b0, "R11 CAS latency 2 select", dp_cl_half, 0);
        cfg_burst = 2'b01;
        repeat (8) @(negedge clk);

        // Directed: closed, hit, miss, auto precharge then re-open.
        do_req(0, 13'd5, 10'd16, 1'b0, 1'b0);
        do_req(0, 13'd5, 10'd20, 1'b1, 1'b0);
        do_req(0, 13'd9, 10'd3, 1'b0, 1'b0);
        do_req(1, 13'd7, 10'd1023, 1'b1, 1'b1);
        chk(m_open[1] == 1'b0, "R7 bank closed after auto-precharge burst", m_open[1], 0);
        do_req(1, 13'd7, 10'd4, 1'b0, 1'b0);
        do_req(1, 13'd7, 10'd8, 1'b0, 1'b1);
        do_req(1, 13'd7, 10'd9, 1'b1, 1'b0);

        // Directed: refresh with banks left open needs precharge-all.
        do_req(2, 13'd100, 10'd0, 1'b0, 1'b0);
        r0 = nref; p0 = npreall;
        repeat (T_REFI + 40) @(negedge clk);
        chk(nref > r0, "R8 refresh issued while idle", nref, r0 + 1);
        chk(npreall > p0, "R9 precharge-all before refresh with open banks", npreall, p0 + 1);

        // Random traffic over the three burst lengths.
        for (int n = 0; n < 480; n++) begin
            if (n % 160 == 0) begin
                cfg_burst = 2'(n / 160);
                repeat (10) @(negedge clk);
                chk(int'(dp_burst_beats) == beats_exp(cfg_burst), "R10 burst length decode",
                    dp_burst_beats, beats_exp(cfg_burst));
            end
            do_req(int'($urandom % 4), ROW_W'($urandom % 3), COL_W'($urandom),
                   1'($urandom), ($urandom % 4) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end

        repeat (20) @(negedge clk);
        chk(cyc - t_ref <= T_REFI, "R8 refresh interval at end", cyc - t_ref, T_REFI);
        chk(nref >= 3, "R8 refresh count over run", nref, 3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule